// File: doc/BRIEF.md
# SCSI Transfer Count and Host Address Tracker

This block keeps the bookkeeping for one SCSI data transfer. It holds a 24-bit count of bytes still to move and a 32-bit host address. The address moves up by one each time the count moves down by one. Software loads both values through byte-wide register writes. A one-cycle strobe from the data path says that a byte has been safely moved. That strobe is the only event that advances the pair. Starting a transfer does not advance them.

Two status bits come from the counter: a zero-count flag and a wrap flag. The wrap flag records that the counter stepped down past zero. Software clears it by writing a one to a write-only clear register, which sits at the same address as the read-only status register. The zero-count flag follows the count and cannot be cleared by software. Each status bit has its own enable. The interrupt output is the OR of the status bits that are both set and enabled. A control register provides a bit that clears the counter in one step.

Top module: `xfer_tracker`

## Requirements
- R1: The count is read and written as three byte registers at 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 23:16). A write replaces only the addressed byte.
- R2: Each strobe on byte_moved lowers the count by exactly one. The count does not change in a cycle with neither a strobe nor a register write.
- R3: The host address is read and written as bytes at 0x14 (bits 7:0) through 0x17 (bits 31:24). Each accepted strobe raises it by one, and it rolls over from 0xFFFFFFFF to 0.
- R4: Bit 2 of the status register at 0x0B reads 1 exactly when the count is 0x000000. Writing to 0x0B does not change this bit.
- R5: A strobe taken while the count is zero sets the count to 0xFFFFFF and sets the wrap flag, which is bit 3 of 0x0B.
- R6: A write to 0x0B clears the wrap flag when data bit 3 is 1 and leaves it unchanged when data bit 3 is 0. If a wrap happens in the same cycle as the clear, the flag ends up set.
- R7: The enable register at 0x10 has its enables at bit 2 (zero-count) and bit 3 (wrap), and reads back only those two bits. irq is 1 exactly when some status bit and its enable are both 1.
- R8: Writing 0x01 with data bit 4 set clears the count to zero. Bit 4 at 0 has no effect, and 0x01 always reads 0x00.
- R9: A strobe in the same cycle as a write to a count byte, an address byte, or a clear through bit 4 of 0x01 is dropped. Only the written register changes, and no wrap is flagged.
- R10: After reset the count, address, wrap flag and enables are zero, so status reads 0x04 and irq is 0. Reads from unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| byte_moved | input | 1 | One byte has been safely transferred |
| irq | output | 1 | Interrupt request, OR of enabled status bits |

## Verification
A register write or an accepted strobe takes effect at the next rising edge. The changed value shows on reg_rdata in the same cycle, because the read path is combinational. The zero-count flag and irq are formed from register state without further delay, so they are due in the same cycle as the count or enable they depend on. The bench changes inputs on the falling edge and samples reg_rdata and irq 1 ns after it sets the read address, which is always between two rising edges. Every expected value is therefore the result of all writes and strobes issued so far, computed arithmetically in the bench.

// File: rtl/xfer_trk_pkg.sv
package xfer_trk_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] CTRL_ADDR = 5'h01;
    localparam logic [REG_AW-1:0] CNT_BASE  = 5'h08;
    localparam logic [REG_AW-1:0] STAT_ADDR = 5'h0B;
    localparam logic [REG_AW-1:0] IEN_ADDR  = 5'h10;
    localparam logic [REG_AW-1:0] HADR_BASE = 5'h14;

    localparam int DONE_BIT  = 2;
    localparam int WRAP_BIT  = 3;
    localparam int CLRCNT_BIT = 4;

    typedef struct packed {
        logic wrap;
        logic done;
    } stat_t;

    function automatic logic [7:0] stat_to_byte(stat_t s);
        logic [7:0] b;
        b = 8'h00;
        b[DONE_BIT] = s.done;
        b[WRAP_BIT] = s.wrap;
        return b;
    endfunction

    function automatic stat_t byte_to_stat(logic [7:0] b);
        stat_t s;
        s.done = b[DONE_BIT];
        s.wrap = b[WRAP_BIT];
        return s;
    endfunction

endpackage

// File: rtl/xfer_regmap.sv
module xfer_regmap
    import xfer_trk_pkg::*;
#(
    parameter int CNT_BYTES = 3,
    parameter int ADR_BYTES = 4,
    localparam int CNT_W = 8 * CNT_BYTES,
    localparam int ADR_W = 8 * ADR_BYTES
) (
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic [CNT_W-1:0]     count,
    input  logic [ADR_W-1:0]     haddr,
    input  stat_t                status,
    input  stat_t                enables,
    output logic [CNT_BYTES-1:0] cnt_we,
    output logic [ADR_BYTES-1:0] adr_we,
    output logic                 cnt_clr,
    output logic                 stat_we,
    output logic                 ien_we,
    output logic [7:0]           reg_rdata
);

    for (genvar i = 0; i < CNT_BYTES; i++) begin : g_cnt_dec
        assign cnt_we[i] = reg_wr && (reg_addr == REG_AW'(CNT_BASE + i));
    end

    for (genvar j = 0; j < ADR_BYTES; j++) begin : g_adr_dec
        assign adr_we[j] = reg_wr && (reg_addr == REG_AW'(HADR_BASE + j));
    end

    assign cnt_clr = reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[CLRCNT_BIT];
    assign stat_we = reg_wr && (reg_addr == STAT_ADDR);
    assign ien_we  = reg_wr && (reg_addr == IEN_ADDR);

    always_comb begin
        reg_rdata = 8'h00;
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (reg_addr == REG_AW'(CNT_BASE + i))
                reg_rdata = count[8*i +: 8];
        end
        for (int j = 0; j < ADR_BYTES; j++) begin
            if (reg_addr == REG_AW'(HADR_BASE + j))
                reg_rdata = haddr[8*j +: 8];
        end
        if (reg_addr == STAT_ADDR)
            reg_rdata = stat_to_byte(status);
        if (reg_addr == IEN_ADDR)
            reg_rdata = stat_to_byte(enables);
    end

endmodule

// File: rtl/xfer_count.sv
module xfer_count #(
    parameter int NBYTES = 3,
    localparam int W = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBYTES-1:0] byte_we,
    input  logic [7:0]        wdata,
    input  logic              clr,
    input  logic              step,
    output logic [W-1:0]      count,
    output logic              is_zero,
    output logic              wrap_evt
);

    logic [W-1:0] nxt;

    assign is_zero  = (count == '0);
    assign wrap_evt = step && is_zero;

    always_comb begin
        nxt = count;
        if (|byte_we) begin
            for (int i = 0; i < NBYTES; i++)
                if (byte_we[i]) nxt[8*i +: 8] = wdata;
        end else if (clr) begin
            nxt = '0;
        end else if (step) begin
            nxt = count - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
    parameter int NBYTES = 4,
    localparam int W = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBYTES-1:0] byte_we,
    input  logic [7:0]        wdata,
    input  logic              step,
    output logic [W-1:0]      haddr
);

    logic [W-1:0] nxt;

    always_comb begin
        nxt = haddr;
        if (|byte_we) begin
            for (int i = 0; i < NBYTES; i++)
                if (byte_we[i]) nxt[8*i +: 8] = wdata;
        end else if (step) begin
            nxt = haddr + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) haddr <= '0;
        else     haddr <= nxt;
    end

endmodule

// File: rtl/xfer_status.sv
module xfer_status
    import xfer_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       count_zero,
    input  logic       wrap_evt,
    input  logic       stat_we,
    input  logic       ien_we,
    input  logic [7:0] wdata,
    output stat_t      status,
    output stat_t      enables,
    output logic       wrap_flag,
    output logic       done_flag,
    output logic       irq
);

    logic  wrap_q;
    stat_t ien_q;
    stat_t clr_req;

    assign clr_req = byte_to_stat(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            wrap_q <= 1'b0;
        end else if (wrap_evt) begin
            wrap_q <= 1'b1;
        end else if (stat_we && clr_req.wrap) begin
            wrap_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         ien_q <= '0;
        else if (ien_we) ien_q <= byte_to_stat(wdata);
    end

    assign status.wrap = wrap_q;
    assign status.done = count_zero;
    assign enables     = ien_q;
    assign wrap_flag   = wrap_q;
    assign done_flag   = count_zero;
    assign irq         = |(stat_to_byte(status) & stat_to_byte(ien_q));

endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
    import xfer_trk_pkg::*;
#(
    parameter int CNT_BYTES = 3,
    parameter int ADR_BYTES = 4,
    localparam int CNT_W = 8 * CNT_BYTES,
    localparam int ADR_W = 8 * ADR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              byte_moved,
    output logic              irq
);

    logic [CNT_BYTES-1:0] cnt_we;
    logic [ADR_BYTES-1:0] adr_we;
    logic                 cnt_clr;
    logic                 stat_we;
    logic                 ien_we;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADR_W-1:0]     haddr_q;
    logic                 cnt_zero;
    logic                 wrap_evt;
    logic                 step_ok;
    logic                 wrap_flag;
    logic                 done_flag;
    stat_t                status;
    stat_t                enables;

    // A strobe is dropped when software touches the counter or the address.
    assign step_ok = byte_moved && !(|cnt_we) && !(|adr_we) && !cnt_clr;

    xfer_regmap #(.CNT_BYTES(CNT_BYTES), .ADR_BYTES(ADR_BYTES)) u_map (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .count    (cnt_q),
        .haddr    (haddr_q),
        .status   (status),
        .enables  (enables),
        .cnt_we   (cnt_we),
        .adr_we   (adr_we),
        .cnt_clr  (cnt_clr),
        .stat_we  (stat_we),
        .ien_we   (ien_we),
        .reg_rdata(reg_rdata)
    );

    xfer_count #(.NBYTES(CNT_BYTES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .byte_we (cnt_we),
        .wdata   (reg_wdata),
        .clr     (cnt_clr),
        .step    (step_ok),
        .count   (cnt_q),
        .is_zero (cnt_zero),
        .wrap_evt(wrap_evt)
    );

    xfer_addr #(.NBYTES(ADR_BYTES)) u_adr (
        .clk    (clk),
        .rst    (rst),
        .byte_we(adr_we),
        .wdata  (reg_wdata),
        .step   (step_ok),
        .haddr  (haddr_q)
    );

    xfer_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .count_zero(cnt_zero),
        .wrap_evt  (wrap_evt),
        .stat_we   (stat_we),
        .ien_we    (ien_we),
        .wdata     (reg_wdata),
        .status    (status),
        .enables   (enables),
        .wrap_flag (wrap_flag),
        .done_flag (done_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/xfer_tracker_chk.sv
module xfer_tracker_chk #(
    parameter int CNT_W = 24,
    parameter int ADR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             byte_moved,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [ADR_W-1:0] haddr,
    input logic             wrap_flag,
    input logic             done_flag
);

    // R2: a lone strobe lowers the count by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (byte_moved && !reg_wr) |=> (count == $past(count) - CNT_W'(1)));

    // R2: without strobe or write the count holds
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!byte_moved && !reg_wr) |=> $stable(count));

    // R3: a lone strobe raises the address by one
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_moved && !reg_wr) |=> (haddr == $past(haddr) + ADR_W'(1)));

    // R5: stepping from zero raises the wrap flag and gives all ones
    assert_wrap_set_R5: assert property (@(posedge clk) disable iff (rst)
        (byte_moved && !reg_wr && count == '0) |=> (wrap_flag && count == '1));

    // R6: the wrap flag only drops on a register write
    assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag && !reg_wr) |=> wrap_flag);

    // R7: an interrupt needs some status bit set
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (wrap_flag || done_flag));

endmodule

bind xfer_tracker xfer_tracker_chk #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .byte_moved(byte_moved),
    .irq       (irq),
    .count     (cnt_q),
    .haddr     (haddr_q),
    .wrap_flag (wrap_flag),
    .done_flag (done_flag)
);

// File: tb/xfer_tracker_test.sv
module xfer_tracker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       byte_moved = 1'b0;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xfer_tracker uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .byte_moved(byte_moved),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_strobe(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; byte_moved = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; byte_moved = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        byte_moved = 1'b1;
        @(negedge clk);
        byte_moved = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_count(output logic [23:0] v);
        logic [7:0] b;
        for (int i = 0; i < 3; i++) begin
            rd(5'(8'h08 + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic rd_addr(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(5'(8'h14 + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic load_count(logic [23:0] v);
        for (int i = 0; i < 3; i++) wr(5'(8'h08 + i), v[8*i +: 8]);
    endtask

    task automatic load_addr(logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(5'(8'h14 + i), v[8*i +: 8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] c;
        logic [31:0] a;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        rd_count(c);       check("R10 count", c, 0);
        rd_addr(a);        check("R10 addr", a, 0);
        rd(5'h0B, b);      check("R10 status", b, 8'h04);
        rd(5'h10, b);      check("R10 enables", b, 8'h00);
        check("R10 irq", irq, 0);
        rd(5'h1F, b);      check("R10 unmapped", b, 8'h00);

        // R1 R2 R3 R4: count down from each start value, address up in step
        for (int n = 1; n <= 12; n++) begin
            logic [23:0] start;
            logic [31:0] base;
            start = 24'(n) | (n > 10 ? 24'h010000 : 24'h0);
            base  = 32'h1000_0000 * 32'(n) + 32'hFF0;
            load_count(start);
            load_addr(base);
            rd_count(c); check("R1 load count", c, start);
            rd_addr(a);  check("R3 load addr", a, base);
            for (int k = 1; k <= n; k++) begin
                strobe();
                rd_count(c); check("R2 count step", c, start - 24'(k));
                rd_addr(a);  check("R3 addr step", a, base + 32'(k));
                rd(5'h0B, b);
                check("R4 done bit", 32'(b[2]), 32'((start - 24'(k)) == 0));
            end
        end

        // R1: single byte replace
        load_count(24'h123456);
        wr(5'h09, 8'hAB);
        rd_count(c); check("R1 byte replace", c, 24'h12AB56);

        // R5: step from zero wraps
        load_count(24'h000000);
        rd(5'h0B, b); check("R4 done at zero", b, 8'h04);
        strobe();
        rd_count(c); check("R5 wrap count", c, 24'hFFFFFF);
        rd(5'h0B, b); check("R5 wrap status", b, 8'h08);

        // R6: clear with bit3 = 0 keeps, = 1 clears
        wr(5'h0B, 8'hF7);
        rd(5'h0B, b); check("R6 no clear", b, 8'h08);
        wr(5'h0B, 8'h08);
        rd(5'h0B, b); check("R6 clear", b, 8'h00);

        // R4: status write leaves done bit
        load_count(24'h0);
        wr(5'h0B, 8'hFF);
        rd(5'h0B, b); check("R4 done unaffected", b, 8'h04);

        // R6: wrap and clear in the same cycle, set wins
        wr_strobe(5'h0B, 8'h08);
        rd(5'h0B, b); check("R6 set wins", b, 8'h08);
        wr(5'h0B, 8'h08);

        // R7: status and enable sweep
        for (int s = 0; s < 4; s++) begin
            wr(5'h0B, 8'h08);
            if (s[1]) begin
                load_count(24'h0);
                strobe();
            end
            load_count(s[0] ? 24'h0 : 24'h5);
            for (int e = 0; e < 16; e++) begin
                logic [7:0] en;
                en = 8'(e) << 2;
                wr(5'h10, en);
                rd(5'h10, b);
                check("R7 enable readback", b, en & 8'h0C);
                check("R7 irq", irq,
                      32'(((en[2] & s[0]) | (en[3] & s[1])) != 0));
            end
        end
        wr(5'h10, 8'h00);
        wr(5'h0B, 8'h08);

        // R8: control clear
        load_count(24'h123456);
        wr(5'h01, 8'hEF);
        rd_count(c); check("R8 bit4 clear no effect", c, 24'h123456);
        wr(5'h01, 8'h10);
        rd_count(c); check("R8 count cleared", c, 0);
        rd(5'h01, b); check("R8 ctrl reads zero", b, 8'h00);

        // R9: collisions drop the strobe
        load_count(24'h000005);
        load_addr(32'h0000_0100);
        wr_strobe(5'h08, 8'h09);
        rd_count(c); check("R9 count write wins", c, 24'h000009);
        rd_addr(a);  check("R9 addr held", a, 32'h100);
        wr_strobe(5'h15, 8'h02);
        rd_count(c); check("R9 count held", c, 24'h000009);
        rd_addr(a);  check("R9 addr write wins", a, 32'h200);
        load_count(24'h0);
        wr_strobe(5'h08, 8'h00);
        rd_count(c); check("R9 no wrap count", c, 0);
        rd(5'h0B, b); check("R9 no wrap flag", b, 8'h04);
        load_count(24'h000003);
        wr_strobe(5'h01, 8'h10);
        rd_count(c); check("R9 clear wins", c, 0);
        rd(5'h0B, b); check("R9 clear no wrap", b, 8'h04);

        // R3: address rollover
        load_addr(32'hFFFF_FFFF);
        load_count(24'h000002);
        strobe();
        rd_addr(a);  check("R3 addr rollover", a, 0);
        rd_count(c); check("R2 count with rollover", c, 24'h1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule